// File: doc/BRIEF.md
# Dual PWM Generator with Per-Output Routing

This block holds two pulse-width generators. They run from the same clock and each is set by its own 10-bit control word. A routing layer sits behind them and resolves each of eight output lines. A line follows one of the two generators when its enable bit is set. Otherwise it carries its own static level. A second mask picks which generator drives each enabled line.

Register writes arrive as parallel values, each with a one-cycle load strobe. A generator control word is first held as pending. It becomes active only when that generator finishes its current period, so a pulse is never cut short or stretched by a write. The routed result is registered, which keeps the output lines free of glitches.

Top module: `dual_pwm_router`

## Requirements
- R1: While reset is low, every output is 0. Reset clears both control words to frequency code 00 with duty 0, and clears the enable and map masks to 0.
- R2: In a control word, bits 9:8 are the frequency code and bits 7:0 are the duty. Code 00 gives a period of 1024 clocks, code 01 gives 512 clocks and code 10 gives 256 clocks.
- R3: Each period has 256 equal steps. A generator is high while its step index is below the duty, so it is high for duty × (period/256) clocks in every period.
- R4: With duty 0 and a code other than 11, the generator stays low.
- R5: With duty 255, the generator is high for all but one step of each period. It is never high for the whole period.
- R6: With code 11, the generator is constantly high, whatever the duty holds.
- R7: A control word that is loaded takes effect only at the next period boundary of its generator. The step counter starts again from 0 at every boundary.
- R8: When enable bit n is 0, output n equals static level n.
- R9: When enable bit n is 1, output n follows generator 0 if map bit n is 0, and generator 1 if map bit n is 1.
- R10: The map bits have no effect on an output whose enable bit is 0.
- R11: Each output is registered. A change of static level appears on the output one clock after the edge at which it is sampled.
- R12: The two generators run independently. Each has its own frequency, duty and period phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared generator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgLoad0 | input | 1 | Load strobe for generator 0 control word |
| cfgWord0 | input | 10 | Generator 0 control word (frequency code, duty) |
| cfgLoad1 | input | 1 | Load strobe for generator 1 control word |
| cfgWord1 | input | 10 | Generator 1 control word (frequency code, duty) |
| enLoad | input | 1 | Load strobe for the enable mask |
| enMask | input | 8 | Per-output generator enable |
| mapLoad | input | 1 | Load strobe for the map mask |
| mapMask | input | 8 | Per-output generator select |
| staticLvl | input | 8 | Static levels used by outputs that are not enabled |
| outLvl | output | 8 | Resolved output levels |

## Verification
The assertions check several rules on every clock:
- outputs are low during reset;
- every output with a clear enable bit copies its static level one cycle later;
- a generator in code 11 drives its mapped outputs high, and one with duty 0 drives them low;
- an active control word never changes except at its generator's period boundary.

The exact number of high clocks per period for each frequency and duty can only be shown by the bench's scenarios, which count the clocks over full windows. The same holds for the 255/256 limit, for an old duty being kept through a period after a write lands mid-period, and for map changes on disabled lines. A cycle-level reference model in the bench also compares every output on every cycle.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int DUTY_W  = 8;
  localparam int FREQ_W  = 2;
  localparam int CFG_W   = FREQ_W + DUTY_W;
  localparam int NUM_GEN = 2;
  localparam int CNT_W   = DUTY_W + 2;

  typedef enum logic [FREQ_W-1:0] {
    FREQ_SLOW = 2'b00,
    FREQ_MID  = 2'b01,
    FREQ_FAST = 2'b10,
    FREQ_FULL = 2'b11
  } freqSel_e;

  typedef struct packed {
    freqSel_e            freq;
    logic [DUTY_W-1:0]   duty;
  } genCfg_t;

  typedef struct packed {
    logic [NUM_GEN-1:0] commit;
  } dpStrb_t;
endpackage

// File: rtl/dpwm_ctrl.sv
module dpwm_ctrl
  import dpwm_pkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_GEN-1:0]        cfgLoad,
  input  genCfg_t [NUM_GEN-1:0]     cfgIn,
  input  logic                      enLoad,
  input  logic [NUM_OUT-1:0]        enIn,
  input  logic                      mapLoad,
  input  logic [NUM_OUT-1:0]        mapIn,
  input  logic [NUM_GEN-1:0]        periodEnd,
  output genCfg_t [NUM_GEN-1:0]     actCfg,
  output logic [NUM_OUT-1:0]        enQ,
  output logic [NUM_OUT-1:0]        mapQ,
  output dpStrb_t                   strb
);
  genCfg_t [NUM_GEN-1:0] pendCfg;

  // A written word waits as pending; it is promoted only at the period end.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendCfg <= '0;
      actCfg  <= '0;
    end else begin
      for (int g = 0; g < NUM_GEN; g++) begin
        if (cfgLoad[g])   pendCfg[g] <= cfgIn[g];
        if (periodEnd[g]) actCfg[g]  <= pendCfg[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enQ  <= '0;
      mapQ <= '0;
    end else begin
      if (enLoad)  enQ  <= enIn;
      if (mapLoad) mapQ <= mapIn;
    end
  end

  // The datapath restarts its step counter whenever a word is committed.
  always_comb strb.commit = periodEnd;
endmodule

// File: rtl/dpwm_datapath.sv
module dpwm_datapath
  import dpwm_pkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  dpStrb_t                strb,
  input  genCfg_t [NUM_GEN-1:0]  actCfg,
  input  logic [NUM_OUT-1:0]     enQ,
  input  logic [NUM_OUT-1:0]     mapQ,
  input  logic [NUM_OUT-1:0]     staticLvl,
  output logic [NUM_GEN-1:0]     periodEnd,
  output logic [NUM_OUT-1:0]     outLvl
);
  localparam logic [CNT_W-1:0] LAST_SLOW = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LAST_MID  = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] LAST_FAST = {2'b00, {DUTY_W{1'b1}}};

  logic [NUM_GEN-1:0][CNT_W-1:0]  cnt;
  logic [NUM_GEN-1:0][CNT_W-1:0]  lastCnt;
  logic [NUM_GEN-1:0][DUTY_W-1:0] step;
  logic [NUM_GEN-1:0]             genOut;
  logic [NUM_OUT-1:0]             routed;

  // The frequency code sets how many clocks make one duty step (4, 2 or 1).
  always_comb begin
    for (int g = 0; g < NUM_GEN; g++) begin
      unique case (actCfg[g].freq)
        FREQ_SLOW: begin
          lastCnt[g] = LAST_SLOW;
          step[g]    = cnt[g][CNT_W-1:2];
        end
        FREQ_MID: begin
          lastCnt[g] = LAST_MID;
          step[g]    = cnt[g][CNT_W-2:1];
        end
        default: begin
          lastCnt[g] = LAST_FAST;
          step[g]    = cnt[g][DUTY_W-1:0];
        end
      endcase
      periodEnd[g] = (cnt[g] == lastCnt[g]);
      genOut[g]    = (actCfg[g].freq == FREQ_FULL) ? 1'b1
                                                   : (step[g] < actCfg[g].duty);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      for (int g = 0; g < NUM_GEN; g++) begin
        cnt[g] <= strb.commit[g] ? '0 : cnt[g] + CNT_W'(1);
      end
    end
  end

  always_comb begin
    for (int n = 0; n < NUM_OUT; n++) begin
      routed[n] = enQ[n] ? genOut[mapQ[n]] : staticLvl[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outLvl <= '0;
    else        outLvl <= routed;
  end
endmodule

// File: rtl/dual_pwm_router.sv
module dual_pwm_router
  import dpwm_pkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgLoad0,
  input  logic [CFG_W-1:0]   cfgWord0,
  input  logic               cfgLoad1,
  input  logic [CFG_W-1:0]   cfgWord1,
  input  logic               enLoad,
  input  logic [NUM_OUT-1:0] enMask,
  input  logic               mapLoad,
  input  logic [NUM_OUT-1:0] mapMask,
  input  logic [NUM_OUT-1:0] staticLvl,
  output logic [NUM_OUT-1:0] outLvl
);
  genCfg_t [NUM_GEN-1:0] cfgIn;
  genCfg_t [NUM_GEN-1:0] actCfg;
  logic [NUM_GEN-1:0]    cfgLoad;
  logic [NUM_GEN-1:0]    periodEnd;
  logic [NUM_OUT-1:0]    enQ;
  logic [NUM_OUT-1:0]    mapQ;
  dpStrb_t               strb;

  assign cfgIn[0]   = genCfg_t'(cfgWord0);
  assign cfgIn[1]   = genCfg_t'(cfgWord1);
  assign cfgLoad    = {cfgLoad1, cfgLoad0};

  dpwm_ctrl #(.NUM_OUT(NUM_OUT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgLoad   (cfgLoad),
    .cfgIn     (cfgIn),
    .enLoad    (enLoad),
    .enIn      (enMask),
    .mapLoad   (mapLoad),
    .mapIn     (mapMask),
    .periodEnd (periodEnd),
    .actCfg    (actCfg),
    .enQ       (enQ),
    .mapQ      (mapQ),
    .strb      (strb)
  );

  dpwm_datapath #(.NUM_OUT(NUM_OUT)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .actCfg    (actCfg),
    .enQ       (enQ),
    .mapQ      (mapQ),
    .staticLvl (staticLvl),
    .periodEnd (periodEnd),
    .outLvl    (outLvl)
  );
endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker
  import dpwm_pkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_OUT-1:0]    staticLvl,
  input logic [NUM_OUT-1:0]    outLvl,
  input genCfg_t [NUM_GEN-1:0] actCfg,
  input logic [NUM_OUT-1:0]    enQ,
  input logic [NUM_OUT-1:0]    mapQ,
  input logic [NUM_GEN-1:0]    periodEnd
);
  p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> (outLvl == '0));

  p_static_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((outLvl & ~$past(enQ)) == ($past(staticLvl) & ~$past(enQ))));

  p_full_on_g0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (actCfg[0].freq == FREQ_FULL) |=>
      ((outLvl & $past(enQ & ~mapQ)) == $past(enQ & ~mapQ)));

  p_full_on_g1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (actCfg[1].freq == FREQ_FULL) |=>
      ((outLvl & $past(enQ & mapQ)) == $past(enQ & mapQ)));

  p_duty_off_g0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (actCfg[0].freq != FREQ_FULL && actCfg[0].duty == '0) |=>
      ((outLvl & $past(enQ & ~mapQ)) == '0));

  p_duty_off_g1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (actCfg[1].freq != FREQ_FULL && actCfg[1].duty == '0) |=>
      ((outLvl & $past(enQ & mapQ)) == '0));

  p_hold_g0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !periodEnd[0] |=> $stable(actCfg[0]));

  p_hold_g1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !periodEnd[1] |=> $stable(actCfg[1]));

  p_period_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    periodEnd[0] |=> !periodEnd[0]);
endmodule

bind dual_pwm_router dpwm_checker #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .staticLvl (staticLvl),
  .outLvl    (outLvl),
  .actCfg    (actCfg),
  .enQ       (enQ),
  .mapQ      (mapQ),
  .periodEnd (periodEnd)
);

// File: tb/dual_pwm_router_test.sv
`timescale 1ns/1ps
module dual_pwm_router_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgLoad0 = 1'b0, cfgLoad1 = 1'b0, enLoad = 1'b0, mapLoad = 1'b0;
  logic [9:0] cfgWord0 = '0, cfgWord1 = '0;
  logic [7:0] enMask = '0, mapMask = '0, staticLvl = '0;
  logic [7:0] outLvl;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  string phaseTag = "R1";

  typedef struct { logic [7:0] exp; string tag; } expItem_t;
  expItem_t sbq[$];

  always #5 clk = ~clk;

  dual_pwm_router uut (
    .clk(clk), .rst_n(rst_n),
    .cfgLoad0(cfgLoad0), .cfgWord0(cfgWord0),
    .cfgLoad1(cfgLoad1), .cfgWord1(cfgWord1),
    .enLoad(enLoad), .enMask(enMask),
    .mapLoad(mapLoad), .mapMask(mapMask),
    .staticLvl(staticLvl), .outLvl(outLvl)
  );

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: built from the requirements, it pushes the expected output of every cycle.
  int         mcnt[2];
  logic [9:0] mact[2];
  logic [9:0] mpend[2];
  logic [7:0] men, mmap;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 2; g++) begin mcnt[g] = 0; mact[g] = '0; mpend[g] = '0; end
      men = '0; mmap = '0;
    end else begin
      logic [1:0] raw;
      logic [1:0] term;
      logic [7:0] e;
      for (int g = 0; g < 2; g++) begin
        int sh;
        sh = (mact[g][9:8] == 2'd0) ? 2 : (mact[g][9:8] == 2'd1) ? 1 : 0;
        raw[g]  = (mact[g][9:8] == 2'd3) ? 1'b1 : ((mcnt[g] >> sh) < int'(mact[g][7:0]));
        term[g] = (mcnt[g] == ((256 << sh) - 1));
      end
      for (int n = 0; n < 8; n++) e[n] = men[n] ? raw[mmap[n]] : staticLvl[n];
      sbq.push_back('{exp: e, tag: phaseTag});
      for (int g = 0; g < 2; g++) begin
        if (term[g]) begin mcnt[g] = 0; mact[g] = mpend[g]; end
        else mcnt[g] = mcnt[g] + 1;
      end
      if (cfgLoad0) mpend[0] = cfgWord0;
      if (cfgLoad1) mpend[1] = cfgWord1;
      if (enLoad)  men  = enMask;
      if (mapLoad) mmap = mapMask;
    end
  end

  // Monitor: pops expected items away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 reset output", int'(outLvl), 0);
    end else if (sbq.size() > 0) begin
      expItem_t it;
      it = sbq.pop_front();
      chk({it.tag, " cycle model"}, int'(outLvl), int'(it.exp));
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadCfg(int g, logic [9:0] w);
    @(negedge clk);
    if (g == 0) begin cfgWord0 = w; cfgLoad0 = 1'b1; end
    else        begin cfgWord1 = w; cfgLoad1 = 1'b1; end
    @(negedge clk);
    cfgLoad0 = 1'b0; cfgLoad1 = 1'b0;
  endtask

  task automatic loadEn(logic [7:0] m);
    @(negedge clk); enMask = m; enLoad = 1'b1;
    @(negedge clk); enLoad = 1'b0;
  endtask

  task automatic loadMap(logic [7:0] m);
    @(negedge clk); mapMask = m; mapLoad = 1'b1;
    @(negedge clk); mapLoad = 1'b0;
  endtask

  task automatic measureHigh(int idx, int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (outLvl[idx]) hi++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int hi;
    waitCyc(5);
    rst_n = 1'b1;
    waitCyc(20);
    chk("R1 after reset defaults", int'(outLvl), 0);

    // R2 R3 R12: two generators, different codes and duties
    phaseTag = "R3";
    loadCfg(0, {2'b00, 8'd64});
    loadCfg(1, {2'b01, 8'd100});
    loadMap(8'h02);
    loadEn(8'h03);
    waitCyc(1100);
    measureHigh(0, 1024, hi); chk("R3 code00 duty64 high clocks", hi, 256);
    measureHigh(1, 512, hi);  chk("R12 gen1 code01 duty100 high clocks", hi, 200);
    measureHigh(1, 1024, hi); chk("R2 gen1 code01 two periods", hi, 400);

    phaseTag = "R2";
    loadCfg(0, {2'b10, 8'd37});
    waitCyc(1100);
    measureHigh(0, 256, hi); chk("R2 code10 duty37 high clocks", hi, 37);

    // R5: maximum duty is never fully on
    phaseTag = "R5";
    loadCfg(0, {2'b10, 8'd255});
    waitCyc(300);
    measureHigh(0, 256, hi); chk("R5 code10 duty255", hi, 255);
    loadCfg(1, {2'b00, 8'd255});
    waitCyc(1100);
    measureHigh(1, 1024, hi); chk("R5 code00 duty255", hi, 1020);

    // R4: zero duty stays low
    phaseTag = "R4";
    loadCfg(0, {2'b01, 8'd0});
    waitCyc(600);
    measureHigh(0, 512, hi); chk("R4 duty0 high clocks", hi, 0);

    // R6: code 11 forces on
    phaseTag = "R6";
    loadCfg(1, {2'b11, 8'd5});
    waitCyc(1100);
    measureHigh(1, 300, hi); chk("R6 code11 high clocks", hi, 300);

    // R7: a mid-period write waits for the boundary
    phaseTag = "R7";
    loadCfg(0, {2'b10, 8'd128});
    waitCyc(600);
    begin
      logic prev;
      prev = outLvl[0];
      forever begin
        @(negedge clk);
        if (outLvl[0] && !prev) break;
        prev = outLvl[0];
      end
      hi = 1;
      cfgWord0 = {2'b10, 8'd32}; cfgLoad0 = 1'b1;
      for (int i = 1; i < 256; i++) begin
        @(negedge clk);
        cfgLoad0 = 1'b0;
        if (outLvl[0]) hi++;
      end
      chk("R7 old duty held in current period", hi, 128);
      measureHigh(0, 256, hi); chk("R7 new duty in next period", hi, 32);
    end

    // R8 R11: static pass-through with one clock latency
    phaseTag = "R8";
    loadEn(8'h00);
    waitCyc(2);
    staticLvl = 8'hA5;
    chk("R11 output before edge", int'(outLvl), 0);
    @(negedge clk); chk("R8 static A5 after one clock", int'(outLvl), 8'hA5);
    staticLvl = 8'h5A;
    @(negedge clk); chk("R11 static 5A after one clock", int'(outLvl), 8'h5A);

    // R10: map ignored on disabled outputs
    phaseTag = "R10";
    loadMap(8'hFF);
    waitCyc(3);
    chk("R10 map write no effect", int'(outLvl), 8'h5A);

    // R9: routing selects generator per output
    phaseTag = "R9";
    loadCfg(0, {2'b11, 8'd0});
    loadCfg(1, {2'b10, 8'd0});
    loadMap(8'hF0);
    loadEn(8'hFF);
    waitCyc(600);
    chk("R9 map F0 gen0 on gen1 off", int'(outLvl), 8'h0F);
    loadMap(8'h0F);
    waitCyc(3);
    chk("R9 map 0F swaps routing", int'(outLvl), 8'hF0);

    waitCyc(5);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule